// File: doc/BRIEF.md
# Two-Bank Interrupt Request Controller

This block collects 32 peripheral interrupt lines and presents them to a processor as two request outputs. One is a normal request and one is a fast request. Each output is served by its own bank of registers. Both banks see the same input lines. Each bank keeps its own enable mask, its own choice of level or edge triggering per line, and its own polarity per line. Lines in edge mode hold a pending event until software writes a one to the matching clear bit.

Every input passes through a two-flop synchronizer before any other logic sees it. A line in level mode is pending for as long as its input, adjusted for polarity, is active. A line in edge mode latches an event on the selected transition. A bank's status view is its pending set ANDed with its enable mask. A bank's request output is high when any bit of that status is set.

Software reaches both banks through a single-cycle 32-bit register port. Reads are combinational from the address. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset every mask, mode and polarity register reads 0, no edge event is pending, and both request outputs are low.
- R2: Word addresses select the registers. In the normal bank the raw view is at 0x00, mask at 0x04, clear at 0x08, mode at 0x0C, polarity at 0x10 and masked status at 0x14. The fast bank uses the same layout at 0x20 to 0x34. A write to one bank leaves the other bank unchanged.
- R3: A mask bit of 1 enables a line and 0 blocks it. The status register reads the pending set ANDed with the mask.
- R4: `irq_out` is the OR of the normal bank's status bits. `fiq_out` is the OR of the fast bank's status bits.
- R5: In level mode (mode bit 0), a line is pending while its synchronized input equals the active level: high when the polarity bit is 0, low when it is 1. A change at the input shows in status after the second rising clock edge.
- R6: In edge mode (mode bit 1), a line latches a pending event on a rising input edge when the polarity bit is 0, or a falling edge when it is 1. The event shows in status after the third rising clock edge and stays after the input returns.
- R7: Writing the clear register clears the latched edge events at its 1 bits. Bits written as 0 are untouched. Level-mode lines are not affected by the clear register.
- R8: If an edge event and a clear of the same line meet on the same clock edge, the event stays pending.
- R9: The raw register of each bank returns the synchronized inputs XORed with that bank's polarity register, whatever the mask holds.
- R10: Changing a line's polarity does not create an edge event. A line switched to level mode drops its latched event, so a later return to edge mode starts with nothing pending.
- R11: Reads of the clear register, of offsets 0x18 and 0x1C, of unaligned addresses and of addresses at 0x40 and above return 0. Writes to the raw, status or unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Asynchronous interrupt lines |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_out | output | 1 | Normal bank request |
| fiq_out | output | 1 | Fast bank request |

## Verification
The bench targets these corner cases:
- **Latency.** The bench counts clock edges to the exact cycle on which level and edge events become visible. A synchronizer with a stage missing or added shows up as early or late status.
- **Clear collides with an edge.** A clear write is timed to land on the same edge that detects a new event. A design that gives priority to the clear loses that interrupt.
- **Polarity and mode changes.** Polarity is flipped while the input is idle, and a line is toggled between edge and level mode. A design that compares polarity-adjusted samples invents an edge. A design that keeps the latch through a mode change fires on a stale event.
- **Partial clears and level lines.** Partial clear masks and clears of level-mode lines are used. A design that clears the wrong bits, or lets clear reach level-mode lines, reports the wrong status.
- **Bank isolation.** Cross-bank writes and writes to read-only and unmapped addresses confirm that each bank's state stays its own.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NUM_SRC     = 32;
    localparam int NUM_BANK    = 2;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = NUM_SRC;
    localparam int SYNC_STAGES = 2;
    localparam int WORD_LSB    = 2;
    localparam int SEL_W       = 3;
    localparam int BANK_LSB    = WORD_LSB + SEL_W;   // bank stride 0x20
    localparam int BANK_W      = $clog2(NUM_BANK);

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_RAW    = 3'd0,
        SEL_MASK   = 3'd1,
        SEL_CLEAR  = 3'd2,
        SEL_MODE   = 3'd3,
        SEL_LEVEL  = 3'd4,
        SEL_STATUS = 3'd5
    } reg_sel_e;

    typedef struct packed {
        src_vec_t mask;    // 1 = enabled
        src_vec_t mode;    // 1 = edge, 0 = level
        src_vec_t level;   // 1 = active-low / falling
    } bank_cfg_t;

    typedef bank_cfg_t [NUM_BANK-1:0] cfg_arr_t;
    typedef src_vec_t  [NUM_BANK-1:0] vec_arr_t;

    typedef struct packed {
        logic              hit;
        logic [BANK_W-1:0] bank;
        reg_sel_e          sel;
    } reg_addr_t;

    function automatic reg_addr_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_addr_t r;
        logic [SEL_W-1:0] off;
        off    = a[BANK_LSB-1:WORD_LSB];
        r.bank = a[BANK_LSB +: BANK_W];
        r.hit  = (a[WORD_LSB-1:0] == '0)
              && (a[ADDR_W-1:BANK_LSB+BANK_W] == '0)
              && (off <= SEL_STATUS);
        r.sel  = r.hit ? reg_sel_e'(off) : SEL_RAW;
        return r;
    endfunction

    // Selected transition between the previous and current synchronized sample.
    function automatic src_vec_t edge_hits(input src_vec_t prev, input src_vec_t cur,
                                           input src_vec_t falling);
        return (cur & ~prev & ~falling) | (~cur & prev & falling);
    endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_prev
);
    // chain[STAGES-1] is the synchronized value, chain[STAGES] the one before it
    logic [WIDTH-1:0] chain [STAGES+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i <= STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i <= STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q      = chain[STAGES-1];
    assign q_prev = chain[STAGES];
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  src_vec_t  cur,
    input  src_vec_t  prev,
    input  logic      wr_en,
    input  reg_sel_e  wr_sel,
    input  src_vec_t  wdata,
    output bank_cfg_t cfg,
    output src_vec_t  raw_adj,
    output src_vec_t  latch,
    output src_vec_t  edge_hit,
    output src_vec_t  status,
    output logic      req
);
    src_vec_t clr;
    src_vec_t pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_MASK:  cfg.mask  <= wdata;
                SEL_MODE:  cfg.mode  <= wdata;
                SEL_LEVEL: cfg.level <= wdata;
                default:   ;
            endcase
        end
    end

    assign clr      = (wr_en && wr_sel == SEL_CLEAR) ? wdata : '0;
    // prev/cur are unadjusted samples, so a polarity write alone never forms an edge
    assign edge_hit = edge_hits(prev, cur, cfg.level) & cfg.mode;

    // new event beats a simultaneous clear; level mode empties the latch
    always_ff @(posedge clk) begin
        if (rst) latch <= '0;
        else     latch <= cfg.mode & ((latch & ~clr) | edge_hit);
    end

    assign raw_adj = cur ^ cfg.level;
    assign pending = (cfg.mode & latch) | (~cfg.mode & raw_adj);
    assign status  = pending & cfg.mask;
    assign req     = |status;
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       src_in,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_out,
    output logic              fiq_out
);
    src_vec_t  sync_cur, sync_prev;
    reg_addr_t dec;
    cfg_arr_t  bank_cfg;
    vec_arr_t  bank_raw, bank_latch, bank_edge, bank_status;
    logic [NUM_BANK-1:0] bank_req;

    intc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d      (src_in),
        .q      (sync_cur),
        .q_prev (sync_prev)
    );

    assign dec = decode_addr(bus_addr);

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        intc_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .cur      (sync_cur),
            .prev     (sync_prev),
            .wr_en    (bus_wr && dec.hit && dec.bank == BANK_W'(b)),
            .wr_sel   (dec.sel),
            .wdata    (bus_wdata),
            .cfg      (bank_cfg[b]),
            .raw_adj  (bank_raw[b]),
            .latch    (bank_latch[b]),
            .edge_hit (bank_edge[b]),
            .status   (bank_status[b]),
            .req      (bank_req[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (dec.hit) begin
            case (dec.sel)
                SEL_RAW:    bus_rdata = bank_raw[dec.bank];
                SEL_MASK:   bus_rdata = bank_cfg[dec.bank].mask;
                SEL_MODE:   bus_rdata = bank_cfg[dec.bank].mode;
                SEL_LEVEL:  bus_rdata = bank_cfg[dec.bank].level;
                SEL_STATUS: bus_rdata = bank_status[dec.bank];
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq_out = bank_req[0];
    assign fiq_out = bank_req[1];
endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        irq_out,
    input logic        fiq_out,
    input cfg_arr_t    cfg,
    input vec_arr_t    latch,
    input vec_arr_t    edges
);
    src_vec_t clr0;
    assign clr0 = (bus_wr && bus_addr == 8'h08) ? bus_wdata : '0;

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) && !rst |-> !irq_out && !fiq_out);

    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg[0].mask == '0 |-> !irq_out) and (cfg[1].mask == '0 |-> !fiq_out));

    p_edge_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ((latch[0] & cfg[0].mode & ~clr0) != '0)
        |=> (($past(latch[0] & cfg[0].mode & ~clr0) & ~latch[0]) == '0));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h08 && (edges[0] & bus_wdata) == '0)
        |=> ((latch[0] & $past(bus_wdata)) == '0));

    p_edge_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (edges[0] != '0) |=> (($past(edges[0]) & ~latch[0]) == '0));

    p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[7:6] != 2'b00) |-> (bus_rdata == '0));

    p_known_outputs_r4: assert property (@(posedge clk) disable iff (rst)
        !$isunknown({irq_out, fiq_out}));
endmodule

bind dual_bank_intc intc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .fiq_out   (fiq_out),
    .cfg       (bank_cfg),
    .latch     (bank_latch),
    .edges     (bank_edge)
);

// File: tb/sim_dual_bank_intc.sv
`timescale 1ns/1ps
module sim_dual_bank_intc;
    logic        clk = 0;
    logic        rst = 1;
    logic [31:0] src = '0;
    logic        bus_wr = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out, fiq_out;

    int checks = 0;
    int fails  = 0;

    localparam logic [7:0] I_RAW = 8'h00, I_MASK = 8'h04, I_CLR = 8'h08,
                           I_MODE = 8'h0C, I_LVL = 8'h10, I_STAT = 8'h14;
    localparam logic [7:0] F_RAW = 8'h20, F_MASK = 8'h24, F_CLR = 8'h28,
                           F_MODE = 8'h2C, F_LVL = 8'h30, F_STAT = 8'h34;

    always #10 clk = ~clk;   // 50 MHz

    dual_bank_intc u0 (
        .clk(clk), .rst(rst), .src_in(src), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out), .fiq_out(fiq_out)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, what, act, exp);
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge clk); @(negedge clk);
        bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic reg_is(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        eq(req, $sformatf("reg 0x%h", a), v, exp);
    endtask

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic quiesce();
        src = '0;
        wr(I_MASK, 0); wr(I_MODE, 0); wr(I_LVL, 0);
        wr(F_MASK, 0); wr(F_MODE, 0); wr(F_LVL, 0);
        cyc(3);
        wr(I_CLR, '1); wr(F_CLR, '1);
    endtask

    task automatic t_reset();
        reg_is("R1", I_MASK, 0); reg_is("R1", I_MODE, 0); reg_is("R1", I_LVL, 0);
        reg_is("R1", F_MASK, 0); reg_is("R1", F_MODE, 0); reg_is("R1", F_LVL, 0);
        reg_is("R1", I_STAT, 0); reg_is("R1", F_STAT, 0);
        eq("R1", "outputs", {30'd0, irq_out, fiq_out}, 0);
    endtask

    task automatic t_map();
        quiesce();
        wr(I_MASK, 32'hA5A5_0000);
        reg_is("R2", I_MASK, 32'hA5A5_0000);
        reg_is("R2", F_MASK, 0);
        wr(F_MODE, 32'h0000_00F0);
        reg_is("R2", F_MODE, 32'h0000_00F0);
        reg_is("R2", I_MODE, 0);
        wr(F_LVL, 32'h1234_5678);
        reg_is("R2", F_LVL, 32'h1234_5678);
        reg_is("R2", I_LVL, 0);
    endtask

    task automatic t_level();
        quiesce();
        wr(I_MASK, 32'h8);
        src[3] = 1;
        cyc(1);
        reg_is("R5", I_STAT, 0);
        cyc(1);
        reg_is("R5", I_STAT, 32'h8);
        eq("R4", "irq_out level", irq_out, 1);
        eq("R3", "fiq_out masked", fiq_out, 0);
        wr(I_CLR, 32'h8);
        reg_is("R7", I_STAT, 32'h8);
        wr(I_LVL, 32'h8);
        reg_is("R5", I_STAT, 0);
        src[3] = 0;
        cyc(2);
        reg_is("R5", I_STAT, 32'h8);
        wr(I_MASK, 0);
        reg_is("R3", I_STAT, 0);
        eq("R3", "irq_out masked", irq_out, 0);
    endtask

    task automatic t_edge();
        quiesce();
        wr(I_MODE, 32'h80); wr(I_MASK, 32'h80);
        src[7] = 1;
        cyc(2);
        reg_is("R6", I_STAT, 0);
        cyc(1);
        reg_is("R6", I_STAT, 32'h80);
        src[7] = 0;
        cyc(4);
        reg_is("R6", I_STAT, 32'h80);
        wr(I_CLR, 32'hFFFF_FF7F);
        reg_is("R7", I_STAT, 32'h80);
        wr(I_CLR, 32'h80);
        reg_is("R7", I_STAT, 0);
        eq("R7", "irq_out cleared", irq_out, 0);
        wr(I_LVL, 32'h80);
        cyc(3);
        reg_is("R10", I_STAT, 0);
        src[7] = 1;
        cyc(4);
        reg_is("R6", I_STAT, 0);
        src[7] = 0;
        cyc(4);
        reg_is("R6", I_STAT, 32'h80);
    endtask

    task automatic t_collide();
        quiesce();
        wr(I_MODE, 32'h200); wr(I_MASK, 32'h200);
        src[9] = 1;
        cyc(2);
        wr(I_CLR, 32'h200);   // lands on the detecting edge
        reg_is("R8", I_STAT, 32'h200);
        wr(I_CLR, 32'h200);
        reg_is("R8", I_STAT, 0);
        src[9] = 0;
        cyc(3);
        src[9] = 1;
        cyc(4);
        reg_is("R10", I_STAT, 32'h200);
        wr(I_MODE, 0);
        src[9] = 0;
        cyc(3);
        reg_is("R10", I_STAT, 0);
        wr(I_MODE, 32'h200);
        cyc(2);
        reg_is("R10", I_STAT, 0);
    endtask

    task automatic t_raw();
        quiesce();
        src = 32'h0000_1234;
        cyc(3);
        reg_is("R9", F_RAW, 32'h0000_1234);
        wr(F_LVL, 32'hFFFF_0000);
        reg_is("R9", F_RAW, 32'hFFFF_1234);
        reg_is("R9", I_RAW, 32'h0000_1234);
    endtask

    task automatic t_fiq();
        quiesce();
        wr(F_MASK, 32'hC);
        src = 32'hC;
        cyc(3);
        reg_is("R4", F_STAT, 32'hC);
        eq("R4", "fiq_out", fiq_out, 1);
        eq("R4", "irq_out", irq_out, 0);
        wr(F_MASK, 32'h8);
        reg_is("R3", F_STAT, 32'h8);
        eq("R4", "fiq_out one bit", fiq_out, 1);
        src = 32'h4;
        cyc(3);
        eq("R4", "fiq_out none", fiq_out, 0);
    endtask

    task automatic t_unmapped();
        quiesce();
        wr(I_MASK, 32'h0F0F);
        wr(I_STAT, '1); wr(I_RAW, '1); wr(8'h44, '1); wr(8'h18, '1); wr(8'h06, '1);
        reg_is("R11", I_MASK, 32'h0F0F);
        reg_is("R11", I_MODE, 0);
        reg_is("R11", I_LVL, 0);
        reg_is("R11", F_MASK, 0);
        reg_is("R11", I_CLR, 0);
        reg_is("R11", 8'h18, 0);
        reg_is("R11", 8'h44, 0);
        reg_is("R11", 8'h06, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_map();
        t_level();
        t_edge();
        t_collide();
        t_raw();
        t_fiq();
        t_unmapped();
        summary();
        $finish;
    end
endmodule